// File: doc/BRIEF.md
# PCI Configuration Header and Memory Window Decoder

This block sits behind the bus interface of a PCI target. It captures the address and command of each address phase, together with the device-select strobe seen in that cycle. From them it works out two things. One is whether the transaction is a Type 0 configuration access aimed at this function. The other is whether it is a memory access that falls inside one of the two memory windows.

The block also holds the part of the configuration header that the decode depends on. That part is the identity words, the command word with its memory-space enable, and the status word, which reports the DEVSEL timing used by the target state machine. It also holds two memory base address registers that support size discovery. The target state machine uses the hit outputs to decide whether to claim the cycle. It routes configuration reads from the read-data output, and it pulses a write strobe during the data phase of a configuration write.

Top module: `pci_cfg_decoder`

## Requirements
- R1: `cfg_hit` is high only when the captured phase had `idsel` high, a command of 1010 (config read) or 1011 (config write), and address bits [1:0] equal to 00. A config write with `idsel` low changes no register.
- R2: For any command other than 1010/1011, `idsel` is ignored. It never raises `cfg_hit`, and it does not alter the memory hit result.
- R3: Registers are selected by dword index = captured address bits [7:2]. A config write updates only the byte lanes whose active-low enable bit in `wr_be_n` is 0; lane n carries data bits [8n+7:8n].
- R4: Dword 0 reads {device 16'h0B72, vendor 16'h1F3A} and dword 2 reads class/revision 32'h05800002. Both are read-only and are never all ones.
- R5: Dword 1 bits [26:25] (status bits [10:9]) read the DEVSEL timing code, 01 (medium) by default. The other status bits read 0.
- R6: Dword 1 bit 1 is the memory-space enable and is the only writable command bit. All other command bits read 0.
- R7: BAR0 is dword 4. After all ones are written it reads 32'hFFFFFF08: a 256-byte prefetchable memory window with bits [7:4] reading 0.
- R8: BAR1 is dword 5. After all ones are written it reads 32'hFFFFF000: a 4 KB non-prefetchable window with bits [11:0] reading 0.
- R9: With the enable set, a memory read (0110) or memory write (0111) hits a BAR when the address bits above the window size equal its base. `addr_hit` is the OR of `bar_hit`, with bit 0 for BAR0 and bit 1 for BAR1.
- R10: While the memory-space enable is 0, no memory hit is raised.
- R11: Hits and read data reflect the phase captured at the clock edge where `addr_valid` is high, and are valid right after that edge. A write takes effect at the edge where `wr_strobe` is high. After reset there are no hits, the enable is 0 and both BAR bases are 0.
- R12: Unimplemented dwords (3 and 6 to 63) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_valid | input | 1 | High in the first clock of the transaction (address phase) |
| ad_addr | input | 32 | Address from the address phase |
| cbe_cmd | input | 4 | Bus command from the address phase |
| idsel | input | 1 | Device select for configuration, sampled in the address phase |
| wr_strobe | input | 1 | Data-phase strobe for a configuration write |
| wr_data | input | 32 | Configuration write data |
| wr_be_n | input | 4 | Active-low byte enables for the write |
| cfg_hit | output | 1 | Captured phase is a config access for this function |
| addr_hit | output | 1 | Captured phase hits any memory window |
| bar_hit | output | 2 | Per-window memory hit |
| cfg_rdata | output | 32 | Header dword selected by the captured index |

## Verification
Every output depends only on registered state. The hits and read data for an address phase are due in the first sample after the edge that captures `addr_valid`, which is zero cycles of added latency. A write shows in the read data on the next read phase after its strobe edge. The bench drives inputs on the falling edge. It samples on the falling edge after each rising edge, and on every clock it compares all four outputs with a behavioural model that is updated on the same rising edge. Directed reads add explicit checks against constants computed from the requirements at exactly that sample point.

// File: rtl/pcd_pkg.sv
// Shared command encodings and helpers for the configuration decoder.
// Assumes 4-bit bus commands as captured in the address phase.
package pcd_pkg;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int REG_IDX_W    = 6;
    localparam int BAR_BASE_IDX = 4;

    // True for either configuration command.
    function automatic logic is_cfg_cmd(input logic [3:0] c);
        return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
    endfunction

    // True for either memory command.
    function automatic logic is_mem_cmd(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction
endpackage

// File: rtl/pcd_bar.sv
// One memory base address register with size discovery.
// Only bits [31:SIZE_BITS] are stored; lower bits read as fixed type bits.
// Assumes SIZE_BITS >= 4 and a 32-bit memory window anywhere in space.
module pcd_bar #(
    parameter int   SIZE_BITS = 8,
    parameter logic PREFETCH  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be_n,
    input  logic        mem_en,
    input  logic        mem_cycle,
    input  logic [31:0] cyc_addr,
    output logic [31:0] bar_val,
    output logic        hit
);
    localparam int BASE_W = 32 - SIZE_BITS;

    logic [BASE_W-1:0] base_q;
    logic              unused_low;

    assign unused_low = &{1'b0, cyc_addr[SIZE_BITS-1:0]};

    // Store the writable base bits lane by lane under the byte enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            for (int i = SIZE_BITS; i < 32; i++) begin
                if (!wr_be_n[i/8]) base_q[i-SIZE_BITS] <= wr_data[i];
            end
        end
    end

    // Compose the read value: base, zero size bits, type bits.
    always_comb begin
        bar_val = {base_q, {(SIZE_BITS-4){1'b0}}, PREFETCH, 3'b000};
    end

    // Window match on the upper address bits.
    assign hit = mem_en && mem_cycle && (cyc_addr[31:SIZE_BITS] == base_q);

    AST_BAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bar_val)); // R7
endmodule

// File: rtl/pcd_cfg_regs.sv
// Configuration header: identity words, command/status and read mux.
// Assumes the caller qualifies wr_en with a config-write hit.
module pcd_cfg_regs
    import pcd_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1F3A,
    parameter logic [15:0] DEVICE_ID     = 16'h0B72,
    parameter logic [31:0] CLASS_REV     = 32'h0580_0002,
    parameter logic [1:0]  DEVSEL_TIMING = 2'b01,
    parameter int          NUM_BARS      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_IDX_W-1:0]     reg_idx,
    input  logic [31:0]              wr_data,
    input  logic [3:0]               wr_be_n,
    input  logic [NUM_BARS-1:0][31:0] bar_val,
    output logic                     mem_en,
    output logic [NUM_BARS-1:0]      bar_we,
    output logic [31:0]              rdata
);
    logic [15:0] status_w;
    logic [15:0] command_w;
    logic        cmd_we;
    logic        unused_data;

    assign unused_data = &{1'b0, wr_data[31:2], wr_data[0], wr_be_n[3:1]};
    assign cmd_we      = wr_en && (reg_idx == REG_IDX_W'(1)) && !wr_be_n[0];

    // Memory-space enable is the only writable command bit.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_en <= 1'b0;
        else if (cmd_we) mem_en <= wr_data[1];
    end

    // Route writes to the BAR whose dword index is addressed.
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar_we
        assign bar_we[g] = wr_en && (reg_idx == REG_IDX_W'(BAR_BASE_IDX + g));
    end

    assign status_w  = {5'b0, DEVSEL_TIMING, 9'b0};
    assign command_w = {14'b0, mem_en, 1'b0};

    // Select the header dword for the captured index.
    always_comb begin
        rdata = '0;
        case (reg_idx)
            REG_IDX_W'(0): rdata = {DEVICE_ID, VENDOR_ID};
            REG_IDX_W'(1): rdata = {status_w, command_w};
            REG_IDX_W'(2): rdata = CLASS_REV;
            default: begin
                for (int b = 0; b < NUM_BARS; b++) begin
                    if (reg_idx == REG_IDX_W'(BAR_BASE_IDX + b)) rdata = bar_val[b];
                end
            end
        endcase
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(mem_en)); // R6
endmodule

// File: rtl/pci_cfg_decoder.sv
// Captures each address phase and decodes config and memory hits.
// Assumes addr_valid marks the first clock of the transaction and that
// wr_strobe only comes during the data phase of the captured transaction.
module pci_cfg_decoder
    import pcd_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1F3A,
    parameter logic [15:0] DEVICE_ID     = 16'h0B72,
    parameter logic [31:0] CLASS_REV     = 32'h0580_0002,
    parameter logic [1:0]  DEVSEL_TIMING = 2'b01,
    parameter int          BAR0_BITS     = 8,
    parameter logic        BAR0_PREF     = 1'b1,
    parameter int          BAR1_BITS     = 12,
    parameter logic        BAR1_PREF     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_valid,
    input  logic [31:0] ad_addr,
    input  logic [3:0]  cbe_cmd,
    input  logic        idsel,
    input  logic        wr_strobe,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_be_n,
    output logic        cfg_hit,
    output logic        addr_hit,
    output logic [1:0]  bar_hit,
    output logic [31:0] cfg_rdata
);
    localparam int NUM_BARS = 2;

    logic [31:0]               lat_addr;
    logic [3:0]                lat_cmd;
    logic                      lat_idsel;
    logic                      mem_en;
    logic                      mem_cycle;
    logic                      cfg_wr;
    logic [NUM_BARS-1:0]       bar_we;
    logic [NUM_BARS-1:0][31:0] bar_val;

    // Capture the address phase; reset leaves no command that can hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_cmd   <= '0;
            lat_idsel <= 1'b0;
        end else if (addr_valid) begin
            lat_addr  <= ad_addr;
            lat_cmd   <= cbe_cmd;
            lat_idsel <= idsel;
        end
    end

    // Config decode: device select counts only for Type 0 config commands.
    assign cfg_hit   = lat_idsel && is_cfg_cmd(lat_cmd) && (lat_addr[1:0] == 2'b00);
    assign mem_cycle = is_mem_cmd(lat_cmd);
    assign cfg_wr    = wr_strobe && cfg_hit && (lat_cmd == CMD_CFG_WR);

    pcd_cfg_regs #(
        .VENDOR_ID     (VENDOR_ID),
        .DEVICE_ID     (DEVICE_ID),
        .CLASS_REV     (CLASS_REV),
        .DEVSEL_TIMING (DEVSEL_TIMING),
        .NUM_BARS      (NUM_BARS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .reg_idx (lat_addr[7:2]),
        .wr_data (wr_data),
        .wr_be_n (wr_be_n),
        .bar_val (bar_val),
        .mem_en  (mem_en),
        .bar_we  (bar_we),
        .rdata   (cfg_rdata)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam int   SZ = (g == 0) ? BAR0_BITS : BAR1_BITS;
        localparam logic PF = (g == 0) ? BAR0_PREF : BAR1_PREF;
        pcd_bar #(
            .SIZE_BITS (SZ),
            .PREFETCH  (PF)
        ) u_bar (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bar_we[g]),
            .wr_data   (wr_data),
            .wr_be_n   (wr_be_n),
            .mem_en    (mem_en),
            .mem_cycle (mem_cycle),
            .cyc_addr  (lat_addr),
            .bar_val   (bar_val[g]),
            .hit       (bar_hit[g])
        );
    end

    assign addr_hit = |bar_hit;

    AST_CFG_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_hit && addr_hit)); // R2
    AST_CFG_NEEDS_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !idsel) |=> !cfg_hit); // R1
    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> mem_en); // R10
endmodule

// File: tb/pci_cfg_decoder_bench.sv
module pci_cfg_decoder_bench;
    localparam logic [3:0] C_MRD = 4'b0110, C_MWR = 4'b0111;
    localparam logic [3:0] C_CRD = 4'b1010, C_CWR = 4'b1011;
    localparam logic [31:0] ID_WORD  = 32'h0B72_1F3A;
    localparam logic [31:0] CLS_WORD = 32'h0580_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [31:0] ad_addr = '0;
    logic [3:0]  cbe_cmd = '0;
    logic        idsel = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be_n = 4'hF;
    logic        cfg_hit, addr_hit;
    logic [1:0]  bar_hit;
    logic [31:0] cfg_rdata;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    pci_cfg_decoder u_pci_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ad_addr(ad_addr),
        .cbe_cmd(cbe_cmd), .idsel(idsel), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .wr_be_n(wr_be_n), .cfg_hit(cfg_hit),
        .addr_hit(addr_hit), .bar_hit(bar_hit), .cfg_rdata(cfg_rdata)
    );

    // Behavioural reference state.
    logic [31:0] m_addr, m_bar0, m_bar1;
    logic [3:0]  m_cmd;
    logic        m_idsel, m_en;

    function automatic logic m_cfg();
        return m_idsel && (m_cmd == C_CRD || m_cmd == C_CWR) && m_addr[1:0] == 2'b00;
    endfunction
    function automatic logic [1:0] m_hits();
        logic mem;
        mem = m_en && (m_cmd == C_MRD || m_cmd == C_MWR);
        return {mem && (m_addr >> 12) == (m_bar1 >> 12), mem && (m_addr >> 8) == (m_bar0 >> 8)};
    endfunction
    function automatic logic [31:0] m_rd();
        case (int'(m_addr[7:2]))
            0: return ID_WORD;
            1: return 32'h0200_0000 | {30'd0, m_en, 1'b0};
            2: return CLS_WORD;
            4: return m_bar0 | 32'h8;
            5: return m_bar1;
            default: return 32'h0;
        endcase
    endfunction
    function automatic logic [31:0] merge(input logic [31:0] old, d, input logic [3:0] ben);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) if (!ben[b]) r[8*b +: 8] = d[8*b +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr <= '0; m_cmd <= '0; m_idsel <= 1'b0;
            m_en <= 1'b0; m_bar0 <= '0; m_bar1 <= '0;
        end else begin
            if (addr_valid) begin
                m_addr <= ad_addr; m_cmd <= cbe_cmd; m_idsel <= idsel;
            end
            if (wr_strobe && m_cfg() && m_cmd == C_CWR) begin
                case (int'(m_addr[7:2]))
                    1: if (!wr_be_n[0]) m_en <= wr_data[1];
                    4: m_bar0 <= merge(m_bar0, wr_data, wr_be_n) & 32'hFFFF_FF00;
                    5: m_bar1 <= merge(m_bar1, wr_data, wr_be_n) & 32'hFFFF_F000;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " cfg_hit"}, {31'd0, cfg_hit}, {31'd0, m_cfg()});
            chk({cur_req, " bar_hit"}, {30'd0, bar_hit}, {30'd0, m_hits()});
            chk({cur_req, " addr_hit"}, {31'd0, addr_hit}, {31'd0, |m_hits()});
            chk({cur_req, " cfg_rdata"}, cfg_rdata, m_rd());
        end
    end

    task automatic phase(input logic [31:0] a, input logic [3:0] c, input logic s);
        @(negedge clk);
        addr_valid = 1'b1; ad_addr = a; cbe_cmd = c; idsel = s;
        @(negedge clk);
        addr_valid = 1'b0; idsel = 1'b0;
    endtask

    task automatic cfg_wr(input int idx, input logic [31:0] d, input logic [3:0] ben, input logic s);
        phase({24'd0, 6'(idx), 2'b00}, C_CWR, s);
        wr_strobe = 1'b1; wr_data = d; wr_be_n = ben;
        @(negedge clk);
        wr_strobe = 1'b0; wr_be_n = 4'hF;
    endtask

    task automatic cfg_rd_chk(input string tag, input int idx, input logic [31:0] exp);
        phase({24'd0, 6'(idx), 2'b00}, C_CRD, 1'b1);
        chk(tag, cfg_rdata, exp);
        chk({tag, " hit"}, {31'd0, cfg_hit}, 32'd1);
    endtask

    task automatic mem_chk(input string tag, input logic [31:0] a, input logic [3:0] c,
                           input logic s, input logic [1:0] exp);
        phase(a, c, s);
        chk(tag, {30'd0, bar_hit}, {30'd0, exp});
        chk({tag, " or"}, {31'd0, addr_hit}, {31'd0, |exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R11";
        chk("R11 reset cfg_hit", {31'd0, cfg_hit}, 32'd0);
        chk("R11 reset addr_hit", {31'd0, addr_hit}, 32'd0);
        cfg_rd_chk("R11 reset bar0", 4, 32'h0000_0008);
        cfg_rd_chk("R11 reset bar1", 5, 32'h0);

        cur_req = "R4";
        cfg_rd_chk("R4 ids", 0, ID_WORD);
        cfg_rd_chk("R4 class", 2, CLS_WORD);
        cfg_wr(0, 32'h0, 4'h0, 1'b1);
        cfg_rd_chk("R4 ids read-only", 0, ID_WORD);
        cur_req = "R12";
        cfg_rd_chk("R12 dword3", 3, 32'h0);
        cfg_rd_chk("R12 dword9", 9, 32'h0);
        cur_req = "R5";
        cfg_rd_chk("R5 status devsel", 1, 32'h0200_0000);

        cur_req = "R7";
        cfg_wr(4, 32'hFFFF_FFFF, 4'h0, 1'b1);
        cfg_rd_chk("R7 bar0 size", 4, 32'hFFFF_FF08);
        cur_req = "R8";
        cfg_wr(5, 32'hFFFF_FFFF, 4'h0, 1'b1);
        cfg_rd_chk("R8 bar1 size", 5, 32'hFFFF_F000);

        cur_req = "R3";
        cfg_wr(4, 32'h1234_5600, 4'h0, 1'b1);
        cfg_rd_chk("R3 bar0 full", 4, 32'h1234_5608);
        cfg_wr(4, 32'h40FF_FFFF, 4'b0111, 1'b1);
        cfg_rd_chk("R3 bar0 lane3", 4, 32'h4034_5608);
        cfg_wr(5, 32'h8000_1000, 4'h0, 1'b1);
        cfg_rd_chk("R3 bar1", 5, 32'h8000_1000);

        cur_req = "R1";
        phase(32'h0000_0011, C_CRD, 1'b1);
        chk("R1 low bits 01 no hit", {31'd0, cfg_hit}, 32'd0);
        cfg_wr(4, 32'h0, 4'h0, 1'b0);
        cfg_rd_chk("R1 write without idsel ignored", 4, 32'h4034_5608);

        cur_req = "R10";
        mem_chk("R10 disabled no hit", 32'h4034_5600, C_MRD, 1'b0, 2'b00);

        cur_req = "R6";
        cfg_wr(1, 32'hFFFF_FFFF, 4'h0, 1'b1);
        cfg_rd_chk("R6 command", 1, 32'h0200_0002);

        cur_req = "R9";
        mem_chk("R9 bar0 low edge", 32'h4034_5600, C_MRD, 1'b0, 2'b01);
        mem_chk("R9 bar0 high edge", 32'h4034_56FF, C_MWR, 1'b0, 2'b01);
        mem_chk("R9 bar0 above", 32'h4034_5700, C_MRD, 1'b0, 2'b00);
        mem_chk("R9 bar0 below", 32'h4034_55FF, C_MRD, 1'b0, 2'b00);
        mem_chk("R9 bar1 low edge", 32'h8000_1000, C_MWR, 1'b0, 2'b10);
        mem_chk("R9 bar1 high edge", 32'h8000_1FFF, C_MRD, 1'b0, 2'b10);
        mem_chk("R9 bar1 above", 32'h8000_2000, C_MRD, 1'b0, 2'b00);
        mem_chk("R9 bar1 below", 32'h8000_0FFF, C_MRD, 1'b0, 2'b00);

        cur_req = "R2";
        mem_chk("R2 mem with idsel", 32'h4034_5610, C_MRD, 1'b1, 2'b01);
        chk("R2 mem with idsel no cfg", {31'd0, cfg_hit}, 32'd0);
        mem_chk("R2 other cmd idsel", 32'h4034_5610, 4'b0010, 1'b1, 2'b00);
        chk("R2 other cmd no cfg", {31'd0, cfg_hit}, 32'd0);
        phase(32'h0000_0010, C_CRD, 1'b0);
        chk("R2 cfg cmd without idsel", {31'd0, cfg_hit}, 32'd0);

        cur_req = "R10";
        cfg_wr(1, 32'h0, 4'b1110, 1'b1);
        mem_chk("R10 cleared enable", 32'h4034_5600, C_MRD, 1'b0, 2'b00);
        mem_chk("R10 cleared bar1", 32'h8000_1000, C_MRD, 1'b0, 2'b00);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule